// File: doc/BRIEF.md
# Packet Receive Task Sequencer

This block sequences the receive side of a packet radio modem under host control. The host writes a two-bit task code into a control register. The block then works through the demodulated bit stream, one bit per strobe on `bit_stb`, until that task is finished. Three tasks exist. The first copies two staged bytes into the frame-sync register. The second hunts for that 16-bit sync word and then captures two head control bytes. The third collects an 18-byte data block.

At the end of each task the block pulls `irq_n` low. It then drops back to idle unless the host writes a new task. Reading the status register releases the interrupt. The status byte holds a head-valid flag and two CRC flags, each sampled from an external checker's `crc_ok` line when the task completes.

The host register map is small.
- Write side: address 0 is control. Bits [1:0] hold the task code: 00 idle, 01 load sync, 10 search head, 11 read block. Bit 2 selects transmit (1) or receive (0). Addresses 1 and 2 stage the sync high and low bytes.
- Read side: address 0 is status. Addresses 1 and 2 return the head bytes. Addresses 8 to 25 return data bytes 0 to 17.

The typical host sequence is: load sync, search head, then one or more block reads. Between block reads the host may return to a head search.

Top module: `pkt_rx_seq`

## Requirements
- R1: After reset `irq_n` is 1, and status and every readable byte read 0. Status bits are: [0] head valid, [1] head CRC, [2] block CRC, [3] busy (task not idle), [5:4] current task, [6] transmit select, [7] interrupt pending.
- R2: With task 01, the first accepted bit strobe copies staged byte 1 into the sync high byte. The second strobe copies staged byte 2 into the sync low byte, asserts `irq_n` low and ends the task.
- R3: With task 10, no interrupt is raised when the sync word alone matches. The 16 bits after the match are assembled MSB first into head bytes 1 and 2. On the 16th of those bits, `irq_n` falls, head valid is set and head CRC takes `crc_ok`.
- R4: A sync match counts only the bits received since the search task was written. Bits shifted in under an earlier task never complete a match.
- R5: With task 11, 144 strobes fill data bytes 0 to 17, MSB first. The 144th strobe asserts `irq_n` low and latches `crc_ok` into block CRC. No interrupt is raised before that strobe.
- R6: A read of address 0 with `rd_en` high releases `irq_n` on the next cycle.
- R7: Once a task completes, the task reads idle. Further strobes change no readable byte and do not release the interrupt.
- R8: A control write during an active task restarts the newly written task from its first bit.
- R9: While transmit select is 1, bit strobes are ignored. The task and its progress stay unchanged until receive is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 sync high stage, 2 sync low stage |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Host read strobe; a read of address 0 releases the interrupt |
| rd_addr | input | 5 | Read address: 0 status, 1-2 head bytes, 8-25 data bytes |
| rd_data | output | 8 | Read data for `rd_addr` |
| bit_stb | input | 1 | One-cycle strobe marking a valid received bit |
| rx_bit | input | 1 | Received bit, valid with `bit_stb` |
| crc_ok | input | 1 | CRC verdict from the external checker |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench checks where the interrupt falls for each task, bit by bit. A design that fires on the sync match itself, or one strobe early or late, fails the check made one bit before the last and the check made on the last. It also places the tail of a sync word under a block task and then switches to a search. A design that does not restart the sync window would lock onto those stale bits and interrupt partway through the following noise.

Three further cases are covered:
- A block restarted mid-way: a counter that is not reset would end the block early.
- A stretch of strobes with transmit selected: progress that leaks through would corrupt the buffer or end the task.
- Strobes after a task has finished: a sequencer that fails to fall back to idle would overwrite data bytes.

// File: rtl/pkt_rx_seq_pkg.sv
package pkt_rx_seq_pkg;

  typedef enum logic [1:0] {
    TSK_IDLE = 2'b00,
    TSK_LOAD = 2'b01,
    TSK_SRCH = 2'b10,
    TSK_BLK  = 2'b11
  } task_e;

  localparam int SYNC_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int LOAD_BITS = 2;

endpackage

// File: rtl/pkt_rx_seq_shreg.sv
module pkt_rx_seq_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  assign nxt = {sh_q[W-2:0], din};
  assign q   = sh_q;

  always_comb begin
    sh_d = sh_q;
    if (clr)     sh_d = '0;
    else if (en) sh_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (sh_q[0] == $past(din)));

endmodule

// File: rtl/pkt_rx_seq_bytebuf.sv
module pkt_rx_seq_bytebuf #(
  parameter int N  = 18,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] rsel,
  output logic [7:0]    rdata
);

  logic [7:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[i] <= '0;
      else if (we && widx == IW'(i))     mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(rsel) < N) rdata = mem[rsel];
  end

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(widx) < N));

endmodule

// File: rtl/pkt_rx_seq.sv
module pkt_rx_seq
  import pkt_rx_seq_pkg::*;
#(
  parameter int HEAD_BYTES = 2,
  parameter int BLK_BYTES  = 18,
  parameter int RD_AW      = 5,
  parameter int DATA_BASE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  input  logic [RD_AW-1:0] rd_addr,
  output logic [7:0]       rd_data,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic             crc_ok,
  output logic             irq_n
);

  localparam int HEAD_BITS = HEAD_BYTES * BYTE_W;
  localparam int BLK_BITS  = BLK_BYTES * BYTE_W;
  localparam int CW        = $clog2(BLK_BITS + 1);
  localparam int HIW       = (HEAD_BYTES > 1) ? $clog2(HEAD_BYTES) : 1;
  localparam int DIW       = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
  localparam int FW        = $clog2(SYNC_W + 1);

  task_e          task_q, task_d;
  logic           tx_q, tx_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           hunt_q, hunt_d;
  logic [FW-1:0]  fill_q, fill_d;
  logic           irq_q, irq_d;
  logic           hok_q, hok_d, hcrc_q, hcrc_d, bcrc_q, bcrc_d;
  logic [7:0]     stage_hi_q, stage_lo_q, sync_hi_q, sync_lo_q;

  logic              ctl_wr, stat_rd, adv, in_srch, byte_end, hit;
  logic              head_we, blk_we;
  logic              done_load, done_head, done_blk, done;
  logic [SYNC_W-1:0] sh_q, sh_nxt;
  logic [7:0]        head_rd, blk_rd, status;

  assign ctl_wr   = wr_en && (wr_addr == 2'd0);
  assign stat_rd  = rd_en && (rd_addr == '0);
  assign adv      = bit_stb && !tx_q && (task_q != TSK_IDLE) && !ctl_wr;
  assign in_srch  = (task_q == TSK_SRCH);
  assign byte_end = (cnt_q[2:0] == 3'd7);
  assign hit      = adv && in_srch && hunt_q && (fill_q >= FW'(SYNC_W - 1))
                    && (sh_nxt == {sync_hi_q, sync_lo_q});
  assign head_we  = adv && in_srch && !hunt_q && byte_end;
  assign blk_we   = adv && (task_q == TSK_BLK) && byte_end;

  assign done_load = adv && (task_q == TSK_LOAD) && (cnt_q == CW'(LOAD_BITS - 1));
  assign done_head = adv && in_srch && !hunt_q && (cnt_q == CW'(HEAD_BITS - 1));
  assign done_blk  = adv && (task_q == TSK_BLK) && (cnt_q == CW'(BLK_BITS - 1));
  assign done      = done_load || done_head || done_blk;

  pkt_rx_seq_shreg #(.W(SYNC_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .clr(ctl_wr), .en(adv), .din(rx_bit),
    .q(sh_q), .nxt(sh_nxt)
  );

  pkt_rx_seq_bytebuf #(.N(HEAD_BYTES), .IW(HIW)) u_headbuf (
    .clk(clk), .rst_n(rst_n), .we(head_we), .widx(HIW'(cnt_q >> 3)),
    .wdata(sh_nxt[7:0]), .rsel(HIW'(rd_addr - RD_AW'(1))), .rdata(head_rd)
  );

  pkt_rx_seq_bytebuf #(.N(BLK_BYTES), .IW(DIW)) u_blkbuf (
    .clk(clk), .rst_n(rst_n), .we(blk_we), .widx(DIW'(cnt_q >> 3)),
    .wdata(sh_nxt[7:0]), .rsel(DIW'(rd_addr - RD_AW'(DATA_BASE))), .rdata(blk_rd)
  );

  // next-state
  always_comb begin
    task_d = task_q;
    tx_d   = tx_q;
    cnt_d  = cnt_q;
    hunt_d = hunt_q;
    fill_d = fill_q;
    hok_d  = hok_q;
    hcrc_d = hcrc_q;
    bcrc_d = bcrc_q;
    irq_d  = irq_q;
    if (ctl_wr) begin
      task_d = task_e'(wr_data[1:0]);
      tx_d   = wr_data[2];
      cnt_d  = '0;
      hunt_d = 1'b1;
      fill_d = '0;
      if (task_e'(wr_data[1:0]) == TSK_SRCH) begin
        hok_d  = 1'b0;
        hcrc_d = 1'b0;
      end
      if (task_e'(wr_data[1:0]) == TSK_BLK) bcrc_d = 1'b0;
    end else if (adv) begin
      if (fill_q != FW'(SYNC_W)) fill_d = fill_q + FW'(1);
      if (hit) begin
        hunt_d = 1'b0;
        cnt_d  = '0;
      end else if (!(in_srch && hunt_q)) begin
        cnt_d = cnt_q + CW'(1);
      end
      if (done) begin
        task_d = TSK_IDLE;
        cnt_d  = '0;
      end
      if (done_head) begin
        hok_d  = 1'b1;
        hcrc_d = crc_ok;
      end
      if (done_blk) bcrc_d = crc_ok;
    end
    if (stat_rd) irq_d = 1'b0;
    if (done)    irq_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      task_q <= TSK_IDLE;
      tx_q   <= 1'b0;
      cnt_q  <= '0;
      hunt_q <= 1'b1;
      fill_q <= '0;
      hok_q  <= 1'b0;
      hcrc_q <= 1'b0;
      bcrc_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      task_q <= task_d;
      tx_q   <= tx_d;
      cnt_q  <= cnt_d;
      hunt_q <= hunt_d;
      fill_q <= fill_d;
      hok_q  <= hok_d;
      hcrc_q <= hcrc_d;
      bcrc_q <= bcrc_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi_q <= '0;
      stage_lo_q <= '0;
    end else begin
      if (wr_en && wr_addr == 2'd1) stage_hi_q <= wr_data;
      if (wr_en && wr_addr == 2'd2) stage_lo_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_hi_q <= '0;
      sync_lo_q <= '0;
    end else if (adv && task_q == TSK_LOAD) begin
      if (cnt_q == '0) sync_hi_q <= stage_hi_q;
      else             sync_lo_q <= stage_lo_q;
    end
  end

  assign status = {irq_q, tx_q, task_q, (task_q != TSK_IDLE), bcrc_q, hcrc_q, hok_q};
  assign irq_n  = ~irq_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0)
      rd_data = status;
    else if (rd_addr <= RD_AW'(HEAD_BYTES))
      rd_data = head_rd;
    else if (rd_addr >= RD_AW'(DATA_BASE) && rd_addr < RD_AW'(DATA_BASE + BLK_BYTES))
      rd_data = blk_rd;
  end

  // R6
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done) |=> irq_n);

  // R7
  auto_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (task_q == TSK_IDLE && !irq_n));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q && !ctl_wr) |=> ($stable(cnt_q) && $stable(task_q)));

  // R3
  head_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_n) && $past(task_q) == TSK_SRCH) |-> hok_q);

  // R2
  load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_load |=> ({sync_hi_q, sync_lo_q} == $past({sync_hi_q, stage_lo_q})));

endmodule

// File: tb/pkt_rx_seq_bench.sv
`timescale 1ns/1ps
module pkt_rx_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       bit_stb = 1'b0;
  logic       rx_bit = 1'b0;
  logic       crc_ok = 1'b0;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] last_b0;

  always #2.5 clk = ~clk;

  pkt_rx_seq u_pkt_rx_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .bit_stb(bit_stb),
    .rx_bit(rx_bit), .crc_ok(crc_ok), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic stat_rd();
    @(negedge clk); rd_en = 1'b1; rd_addr = '0;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_stb = 1'b1; rx_bit = b;
    @(negedge clk); bit_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(d[i]);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    peek(5'd0, v);  chk("R1 status", v, 8'h00);
    peek(5'd1, v);  chk("R1 head0", v, 8'h00);
    peek(5'd8, v);  chk("R1 data0", v, 8'h00);
  endtask

  task automatic t_load();
    logic [7:0] v;
    reg_wr(2'd1, 8'hA5);
    reg_wr(2'd2, 8'h3C);
    reg_wr(2'd0, 8'h01);
    send_bit(1'b0);
    chk("R2 no irq after 1st strobe", {7'd0, irq_n}, 8'h01);
    peek(5'd0, v); chk("R2 busy status", v, 8'h18);
    send_bit(1'b0);
    chk("R2 irq after 2nd strobe", {7'd0, irq_n}, 8'h00);
    peek(5'd0, v); chk("R2 idle status", v, 8'h80);
    stat_rd();
    chk("R6 irq released", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_head();
    logic [7:0] v;
    crc_ok = 1'b1;
    reg_wr(2'd0, 8'h02);
    send_bits(8'hF0, 8);
    send_bits(8'hA5, 8);
    send_bits(8'h3C, 8);
    chk("R3 no irq on sync match", {7'd0, irq_n}, 8'h01);
    send_bits(8'h12, 8);
    send_bits(8'h34, 7);
    chk("R3 no irq before last head bit", {7'd0, irq_n}, 8'h01);
    send_bit(1'b0);
    chk("R3 irq on last head bit", {7'd0, irq_n}, 8'h00);
    peek(5'd0, v); chk("R3 status", v, 8'h83);
    peek(5'd1, v); chk("R3 head byte 1", v, 8'h12);
    peek(5'd2, v); chk("R3 head byte 2", v, 8'h34);
    stat_rd();
    chk("R6 irq released after head", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_block(input int pre, input int seed, input logic crc, input logic [7:0] hfl);
    logic [7:0] v;
    crc_ok = crc;
    reg_wr(2'd0, 8'h03);
    if (pre > 0) begin
      for (int i = 0; i < pre; i++) send_bit(1'b1);
      reg_wr(2'd0, 8'h03);   // R8 restart
    end
    for (int i = 0; i < 17; i++) send_bits(8'(i * 13 + seed), 8);
    send_bits(8'(17 * 13 + seed), 7);
    chk("R5 R8 no irq before bit 144", {7'd0, irq_n}, 8'h01);
    send_bit(1'((17 * 13 + seed) & 1));
    chk("R5 irq on bit 144", {7'd0, irq_n}, 8'h00);
    peek(5'd0, v); chk("R5 status", v, 8'h80 | hfl | {5'd0, crc, 2'd0});
    for (int i = 0; i < 18; i++) begin
      peek(5'(8 + i), v);
      chk("R5 data byte", v, 8'(i * 13 + seed));
    end
    last_b0 = 8'(seed);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    peek(5'd0, v); chk("R7 idle task bits", v & 8'h38, 8'h00);
    peek(5'd8, v); chk("R7 data kept", v, last_b0);
    chk("R7 irq held", {7'd0, irq_n}, 8'h00);
    stat_rd();
    chk("R6 irq released after block", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    reg_wr(2'd0, 8'h07);
    for (int i = 0; i < 160; i++) send_bit(1'b0);
    chk("R9 no irq in transmit", {7'd0, irq_n}, 8'h01);
    peek(5'd0, v); chk("R9 status", v, 8'h7B);
    peek(5'd8, v); chk("R9 data untouched", v, last_b0);
  endtask

  task automatic t_stale();
    logic [7:0] v;
    crc_ok = 1'b0;
    reg_wr(2'd0, 8'h03);
    send_bits(8'hA5, 8);
    reg_wr(2'd0, 8'h02);
    send_bits(8'h3C, 8);
    send_bits(8'h12, 8);
    send_bits(8'h34, 8);
    chk("R4 stale bits ignored", {7'd0, irq_n}, 8'h01);
    send_bits(8'hA5, 8);
    send_bits(8'h3C, 8);
    send_bits(8'h55, 8);
    send_bits(8'hAA, 8);
    chk("R4 fresh match", {7'd0, irq_n}, 8'h00);
    peek(5'd0, v); chk("R4 status", v, 8'h81);
    peek(5'd1, v); chk("R4 head byte 1", v, 8'h55);
    peek(5'd2, v); chk("R4 head byte 2", v, 8'hAA);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_load();
    t_head();
    t_block(0, 3, 1'b1, 8'h03);
    t_idle();
    t_block(20, 5, 1'b0, 8'h03);
    stat_rd();
    chk("R6 irq released after restart block", {7'd0, irq_n}, 8'h01);
    t_tx();
    t_block(0, 9, 1'b1, 8'h03);
    stat_rd();
    t_stale();
    summary();
  end

endmodule